// File: doc/BRIEF.md
# Chained FIFO Depth Controller

This block builds one deep first-in/first-out queue out of several identical storage slices arranged in a ring. Each slice owns two tokens: a write token and a read token. Only the slice holding the write token stores incoming words, and only the slice holding the read token returns words. When a slice fills its last physical location it fires a one-cycle write hand-off pulse toward its ring neighbour. When it drains its last location it does the same for reading. The neighbour picks the token up on the next clock edge and begins again at its own location zero. The last slice feeds the first, so both tokens go round the ring forever.

The wrapper merges the per-slice status into queue-wide full, empty, almost-full and almost-empty outputs. Each slice counts toward these flags only while it holds the relevant token, so the almost flags describe only the active slice and are approximate for the whole queue. Read data comes from the slice that performed the most recent read. With a single slice the tokens never move and a more-than-half-full flag is available. With two or more slices that flag is held low. Both ports run on one clock.

Top module: `fifo_chain`

## Requirements
- R1: After reset, slice FIRST_IDX holds both tokens and every other slice holds none. full=0, empty=1, almost_full=0, almost_empty=1, half_full=0 and rd_data=0.
- R2: At most one slice holds the write token, and at most one holds the read token, at any time.
- R3: A word is stored on a rising edge only when wr_en=1 and full=0. While wr_en=0 nothing is stored.
- R4: Writing a slice's last location raises its write hand-off pulse for exactly one cycle. The next slice in ring order takes the write token on the following edge. During that one cycle, full reads 1.
- R5: Reading a slice's last location raises its read hand-off pulse for exactly one cycle. The next slice takes the read token on the following edge. During that one cycle, empty reads 1.
- R6: Words come out in the order they were accepted. A word read on an edge appears on rd_data after that edge and stays there until the next accepted read.
- R7: full=1 whenever the write-token slice holds DEPTH words. A write attempted while full=1 stores nothing, so an empty queue accepts exactly SLICES*DEPTH words before it stops.
- R8: empty=1 whenever the read-token slice holds no word. A read attempted while empty=1 returns nothing and leaves rd_data unchanged.
- R9: almost_full = full OR (write-token slice count >= DEPTH-AF_GAP). almost_empty = empty OR (read-token slice count <= AE_GAP).
- R10: With SLICES=1, half_full=1 exactly when the slice holds more than DEPTH/2 words. With SLICES>1, half_full stays 0.
- R11: The last slice passes both tokens back to the first, so the queue keeps working after more than SLICES*DEPTH words have gone through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Most recently read word |
| full | output | 1 | No write can be accepted this cycle |
| empty | output | 1 | No read can be accepted this cycle |
| almost_full | output | 1 | Write-token slice is near its capacity |
| almost_empty | output | 1 | Read-token slice is near exhaustion |
| half_full | output | 1 | More than half occupied (single-slice mode only) |

## Verification
The assertions assume that rst_n is held low across at least one clock edge before the first operation. They also assume DEPTH is at least two, so two hand-off pulses of one slice can never fall on adjacent cycles. The stimulus respects this by starting every run with several reset cycles and using a four-deep slice. Requests are issued freely while full or empty is high, because the block must ignore them. The random phases lean toward writes and then toward reads, so the queue repeatedly reaches both the full and the empty boundary. This also makes the tokens travel round the ring many times.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

   // Per-slice status as seen by the merging logic.
   typedef struct packed {
      logic has_wtok;   // slice owns the write token
      logic has_rtok;   // slice owns the read token
      logic wr_room;    // owns write token and has a free location
      logic wr_slack;   // owns write token and is below the almost-full mark
      logic rd_avail;   // owns read token and holds a word
      logic rd_slack;   // owns read token and is above the almost-empty mark
      logic over_half;  // holds more than half its depth
   } slice_stat_t;

   // Ring predecessor of a slice index.
   function automatic int ring_prev(input int idx, input int n);
      return (idx == 0) ? n - 1 : idx - 1;
   endfunction

endpackage

// File: rtl/fifo_chain_slice.sv
module fifo_chain_slice
   import fifo_chain_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter int DEPTH   = 16,
   parameter int AF_GAP  = 2,
   parameter int AE_GAP  = 2,
   parameter bit CHAINED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_n,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic              rd_en,
   input  logic              wexi,
   input  logic              rexi,
   output logic              wexo,
   output logic              rexo,
   output logic [WIDTH-1:0]  rd_q,
   output logic              rd_fire,
   output slice_stat_t       stat
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] AF_MARK  = CW'(DEPTH - AF_GAP);
   localparam logic [CW-1:0] AE_MARK  = CW'(AE_GAP);
   localparam logic [CW-1:0] HALF_MK  = CW'(DEPTH / 2);

   logic              wtok, rtok;
   logic [AW-1:0]     wptr, rptr;
   logic [CW-1:0]     cnt;
   logic [WIDTH-1:0]  mem [DEPTH];
   logic              do_wr, do_rd, wr_last, rd_last;

   assign do_wr   = wr_en & wtok & (cnt != CNT_FULL);
   assign do_rd   = rd_en & rtok & (cnt != '0);
   assign wr_last = do_wr & (wptr == LAST_LOC);
   assign rd_last = do_rd & (rptr == LAST_LOC);

   // occupancy and pointers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         wptr <= '0;
         rptr <= '0;
      end else begin
         cnt <= cnt + CW'(do_wr) - CW'(do_rd);
         if (do_wr) wptr <= wr_last ? '0 : wptr + AW'(1);
         if (do_rd) rptr <= rd_last ? '0 : rptr + AW'(1);
      end
   end

   // storage, no reset
   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (do_rd) rd_q <= mem[rptr];
   end

   // token ownership: passed round a ring, or pinned in single-slice use
   if (CHAINED) begin : g_pass
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wtok <= ~first_n;
            rtok <= ~first_n;
            wexo <= 1'b0;
            rexo <= 1'b0;
         end else begin
            wexo <= wr_last;
            rexo <= rd_last;
            if (wr_last)   wtok <= 1'b0;
            else if (wexi) wtok <= 1'b1;
            if (rd_last)   rtok <= 1'b0;
            else if (rexi) rtok <= 1'b1;
         end
      end
   end else begin : g_pinned
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wtok <= ~first_n;
            rtok <= ~first_n;
         end
      end
      assign wexo = 1'b0;
      assign rexo = 1'b0;
   end

   assign rd_fire         = do_rd;
   assign stat.has_wtok   = wtok;
   assign stat.has_rtok   = rtok;
   assign stat.wr_room    = wtok & (cnt != CNT_FULL);
   assign stat.wr_slack   = wtok & (cnt < AF_MARK);
   assign stat.rd_avail   = rtok & (cnt != '0);
   assign stat.rd_slack   = rtok & (cnt > AE_MARK);
   assign stat.over_half  = cnt > HALF_MK;

endmodule

// File: rtl/fifo_chain_merge.sv
module fifo_chain_merge
   import fifo_chain_pkg::*;
#(
   parameter int SLICES = 4,
   parameter int WIDTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slice_stat_t       stat  [SLICES],
   input  logic [WIDTH-1:0]  rd_q  [SLICES],
   input  logic [SLICES-1:0] rd_fire,
   output logic              full,
   output logic              empty,
   output logic              almost_full,
   output logic              almost_empty,
   output logic              half_full,
   output logic [WIDTH-1:0]  rd_data
);

   localparam bit HALF_EN = (SLICES == 1);

   logic [SLICES-1:0] src_sel;
   logic              any_room, any_avail, any_wslack, any_rslack, any_half;

   // remember which slice returned the last word
   always_ff @(posedge clk) begin
      if (!rst_n)        src_sel <= '0;
      else if (|rd_fire) src_sel <= rd_fire;
   end

   always_comb begin
      any_room   = 1'b0;
      any_avail  = 1'b0;
      any_wslack = 1'b0;
      any_rslack = 1'b0;
      any_half   = 1'b0;
      rd_data    = '0;
      for (int i = 0; i < SLICES; i++) begin
         any_room   = any_room   | stat[i].wr_room;
         any_avail  = any_avail  | stat[i].rd_avail;
         any_wslack = any_wslack | stat[i].wr_slack;
         any_rslack = any_rslack | stat[i].rd_slack;
         any_half   = any_half   | stat[i].over_half;
         rd_data    = rd_data    | (rd_q[i] & {WIDTH{src_sel[i]}});
      end
   end

   assign full         = ~any_room;
   assign empty        = ~any_avail;
   assign almost_full  = ~any_wslack;
   assign almost_empty = ~any_rslack;
   assign half_full    = HALF_EN & any_half;

endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
   import fifo_chain_pkg::*;
#(
   parameter int SLICES    = 4,
   parameter int DEPTH     = 16,
   parameter int WIDTH     = 16,
   parameter int AF_GAP    = 2,
   parameter int AE_GAP    = 2,
   parameter int FIRST_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty,
   output logic             almost_full,
   output logic             almost_empty,
   output logic             half_full
);

   localparam bit CHAINED = (SLICES > 1);

   if (SLICES < 1)         begin : g_bad_slices $error("SLICES must be at least 1"); end
   if (DEPTH < 2)          begin : g_bad_depth  $error("DEPTH must be at least 2"); end
   if (AF_GAP >= DEPTH)    begin : g_bad_af     $error("AF_GAP must be below DEPTH"); end
   if (AE_GAP >= DEPTH)    begin : g_bad_ae     $error("AE_GAP must be below DEPTH"); end
   if (FIRST_IDX >= SLICES || FIRST_IDX < 0)
                           begin : g_bad_first  $error("FIRST_IDX out of range"); end

   slice_stat_t       stat  [SLICES];
   logic [WIDTH-1:0]  rd_q  [SLICES];
   logic [SLICES-1:0] rd_fire_v;
   logic [SLICES-1:0] wexo_v, rexo_v, wexi_v, rexi_v;
   logic [SLICES-1:0] wtok_v, rtok_v;

   for (genvar i = 0; i < SLICES; i++) begin : g_slice
      assign wexi_v[i] = CHAINED ? wexo_v[ring_prev(i, SLICES)] : 1'b0;
      assign rexi_v[i] = CHAINED ? rexo_v[ring_prev(i, SLICES)] : 1'b0;

      fifo_chain_slice #(
         .WIDTH   (WIDTH),
         .DEPTH   (DEPTH),
         .AF_GAP  (AF_GAP),
         .AE_GAP  (AE_GAP),
         .CHAINED (CHAINED)
      ) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .first_n (1'(i != FIRST_IDX)),
         .wr_en   (wr_en),
         .wr_data (wr_data),
         .rd_en   (rd_en),
         .wexi    (wexi_v[i]),
         .rexi    (rexi_v[i]),
         .wexo    (wexo_v[i]),
         .rexo    (rexo_v[i]),
         .rd_q    (rd_q[i]),
         .rd_fire (rd_fire_v[i]),
         .stat    (stat[i])
      );

      assign wtok_v[i] = stat[i].has_wtok;
      assign rtok_v[i] = stat[i].has_rtok;
   end

   fifo_chain_merge #(
      .SLICES (SLICES),
      .WIDTH  (WIDTH)
   ) u_merge (
      .clk          (clk),
      .rst_n        (rst_n),
      .stat         (stat),
      .rd_q         (rd_q),
      .rd_fire      (rd_fire_v),
      .full         (full),
      .empty        (empty),
      .almost_full  (almost_full),
      .almost_empty (almost_empty),
      .half_full    (half_full),
      .rd_data      (rd_data)
   );

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
   parameter int SLICES    = 4,
   parameter int WIDTH     = 16,
   parameter int FIRST_IDX = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              empty,
   input logic [WIDTH-1:0]  rd_data,
   input logic [SLICES-1:0] wtok_v,
   input logic [SLICES-1:0] rtok_v,
   input logic [SLICES-1:0] wexo_v,
   input logic [SLICES-1:0] rexo_v
);

   localparam logic [SLICES-1:0] FIRST_OH = SLICES'(1) << FIRST_IDX;

   // R1: tokens start in the designated slice
   a_r1_reset_tokens: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wtok_v == FIRST_OH && rtok_v == FIRST_OH));

   // R2: token exclusivity
   a_r2_one_wtok: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wtok_v));
   a_r2_one_rtok: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rtok_v));

   // R4: write hand-off pulse is one cycle wide and the token lands next edge
   a_r4_wpulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      (wexo_v != '0) |=> (wexo_v == '0));
   a_r4_wtok_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wexo_v != '0) |=> $onehot(wtok_v));
   a_r4_wtok_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (wtok_v == '0) |-> (wexo_v != '0));

   // R5: same for the read side
   a_r5_rpulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      (rexo_v != '0) |=> (rexo_v == '0));
   a_r5_rtok_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (rexo_v != '0) |=> $onehot(rtok_v));
   a_r5_rtok_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (rtok_v == '0) |-> (rexo_v != '0));

   // R8: a read request while empty leaves the output word alone
   a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> $stable(rd_data));

endmodule

bind fifo_chain fifo_chain_chk #(
   .SLICES    (SLICES),
   .WIDTH     (WIDTH),
   .FIRST_IDX (FIRST_IDX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (rd_en),
   .empty   (empty),
   .rd_data (rd_data),
   .wtok_v  (wtok_v),
   .rtok_v  (rtok_v),
   .wexo_v  (wexo_v),
   .rexo_v  (rexo_v)
);

// File: tb/tb_fifo_chain.sv
module tb_fifo_chain;

   localparam int N  = 3;
   localparam int D  = 4;
   localparam int W  = 8;
   localparam int AF = 1;
   localparam int AE = 1;
   localparam int SD = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic         full, empty, almost_full, almost_empty, half_full;

   logic         s_wr_en = 1'b0, s_rd_en = 1'b0;
   logic [W-1:0] s_wr_data = '0;
   logic [W-1:0] s_rd_data;
   logic         s_full, s_empty, s_af, s_ae, s_half;

   fifo_chain #(.SLICES(N), .DEPTH(D), .WIDTH(W), .AF_GAP(AF), .AE_GAP(AE), .FIRST_IDX(0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .full(full), .empty(empty), .almost_full(almost_full),
      .almost_empty(almost_empty), .half_full(half_full));

   fifo_chain #(.SLICES(1), .DEPTH(SD), .WIDTH(W), .AF_GAP(AF), .AE_GAP(AE), .FIRST_IDX(0)) dut_single (
      .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_data(s_wr_data), .rd_en(s_rd_en),
      .rd_data(s_rd_data), .full(s_full), .empty(s_empty), .almost_full(s_af),
      .almost_empty(s_ae), .half_full(s_half));

   int tests = 0, fails = 0;
   bit done = 1'b0;

   // reference model state
   int cnt [N];
   int wp  [N];
   int rp  [N];
   int wt = 0, rt = 0, wsrc = 0, rsrc = 0;
   bit wfly = 0, rfly = 0;
   logic [W-1:0] q [$];
   logic [W-1:0] exp_rd = '0;
   int acc_w = 0, acc_r = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_full();
      return wfly || (cnt[wt] == D);
   endfunction
   function automatic bit exp_empty();
      return rfly || (cnt[rt] == 0);
   endfunction

   // one clock: compare at the falling edge, then drive and advance the model
   task automatic step(input bit w, input bit r, input logic [W-1:0] d);
      bit ef, ee, aw, ar;
      @(negedge clk);
      ef = exp_full();
      ee = exp_empty();
      chk(full == ef, "R4 R7 full", int'(full), int'(ef));
      chk(empty == ee, "R5 R8 empty", int'(empty), int'(ee));
      chk(almost_full == (ef || cnt[wt] >= D - AF), "R9 almost_full",
          int'(almost_full), int'(ef || cnt[wt] >= D - AF));
      chk(almost_empty == (ee || cnt[rt] <= AE), "R9 almost_empty",
          int'(almost_empty), int'(ee || cnt[rt] <= AE));
      chk(rd_data == exp_rd, "R2 R3 R6 R11 rd_data", int'(rd_data), int'(exp_rd));
      chk(half_full == 1'b0, "R10 chained half_full", int'(half_full), 0);
      wr_en   = w;
      rd_en   = r;
      wr_data = d;
      aw = w && !ef;
      ar = r && !ee;
      if (wfly) begin
         wt = (wsrc + 1) % N;
         wfly = 0;
      end else if (aw) begin
         acc_w++;
         cnt[wt]++;
         q.push_back(d);
         wp[wt]++;
         if (wp[wt] == D) begin
            wp[wt] = 0;
            wfly = 1;
            wsrc = wt;
         end
      end
      if (rfly) begin
         rt = (rsrc + 1) % N;
         rfly = 0;
      end else if (ar) begin
         acc_r++;
         cnt[rt]--;
         exp_rd = q.pop_front();
         rp[rt]++;
         if (rp[rt] == D) begin
            rp[rt] = 0;
            rfly = 1;
            rsrc = rt;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int pw, pr;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         cnt[i] = 0; wp[i] = 0; rp[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: state straight after reset
      chk(full == 1'b0, "R1 full", int'(full), 0);
      chk(empty == 1'b1, "R1 empty", int'(empty), 1);
      chk(almost_full == 1'b0, "R1 almost_full", int'(almost_full), 0);
      chk(almost_empty == 1'b1, "R1 almost_empty", int'(almost_empty), 1);
      chk(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
      chk(s_half == 1'b0, "R1 half_full", int'(s_half), 0);

      // R7: fill from empty with writes held on
      acc_w = 0;
      for (int i = 0; i < N * D + N + 4; i++) step(1'b1, 1'b0, W'(8'h10 + i));
      step(1'b0, 1'b0, '0);
      chk(acc_w == N * D, "R7 words accepted before full", acc_w, N * D);
      chk(full == 1'b1, "R7 full after fill", int'(full), 1);

      // R8: drain completely, then keep requesting
      acc_r = 0;
      for (int i = 0; i < N * D + N + 4; i++) step(1'b0, 1'b1, '0);
      step(1'b0, 1'b0, '0);
      chk(acc_r == N * D, "R8 words returned before empty", acc_r, N * D);
      chk(empty == 1'b1, "R8 empty after drain", int'(empty), 1);

      // random phases, biased toward filling then draining
      for (int ph = 0; ph < 12; ph++) begin
         case (ph % 3)
            0: begin pw = 80; pr = 30; end
            1: begin pw = 30; pr = 80; end
            default: begin pw = 60; pr = 60; end
         endcase
         for (int c = 0; c < 250; c++)
            step(($urandom % 100) < pw, ($urandom % 100) < pr, W'($urandom));
      end
      for (int i = 0; i < N * D + N + 4; i++) step(1'b0, 1'b1, '0);
      step(1'b0, 1'b0, '0);

      // R10: single-slice mode, half flag
      for (int i = 0; i < 9; i++) begin
         step(1'b0, 1'b0, '0);
         chk(s_half == (((i < 5) ? i : 5) > SD / 2), "R10 single half_full",
             int'(s_half), int'(((i < 5) ? i : 5) > SD / 2));
         chk(s_full == 1'b0, "R7 single full", int'(s_full), 0);
         s_wr_en   = (i < 5);
         s_wr_data = W'(8'hA0 + i);
      end
      step(1'b0, 1'b0, '0);
      s_rd_en = 1'b1;
      step(1'b0, 1'b0, '0);
      s_rd_en = 1'b0;
      chk(s_rd_data == W'(8'hA0), "R6 single first word", int'(s_rd_data), 8'hA0);
      chk(s_half == 1'b0, "R10 single half after read", int'(s_half), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule